// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block carries out the data movement of one DMA channel after the channel has been armed and its settings loaded. A one-cycle `start` pulse captures a source pointer and a destination pointer, a step mode for each pointer, the unit size (byte or 16-bit word), a length setting and an interrupt-mask bit. For every unit the engine issues a read at the source pointer and then a write of the same data at the destination pointer. Both accesses go through a single memory request port. After each access it moves the pointer that was used by that pointer's own step.

The length can be a fixed count given with the configuration. It can also be taken from the first unit read at the source, which is then consumed and not copied. A shared `grant` input arbitrates the memory port: a request that is not granted is held unchanged. When the count is reached the engine returns to idle, pulses `done`, and sets a sticky interrupt flag if the mask bit allows it. An `abort` input stops the engine at once and raises no interrupt.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `irq_flag` and `irq_req` are all 0.
- R2: Each unit is a granted read at the source pointer followed by a granted write at the destination pointer. The write carries the data that was read. In byte mode (`word_mode`=0) bits 15:8 of the written data are 0.
- R3: Each pointer moves after its own granted access according to its 2-bit mode: 00 holds, 01 adds 1, 10 adds 2, 11 subtracts 1. Arithmetic wraps modulo 2^16. The source and destination modes act independently.
- R4: When `len_sel` is 000 or 111 the engine moves exactly `xfer_len` units. A `xfer_len` of 0 completes with no memory access.
- R5: For any other `len_sel` the first source unit is read, is not written, and the source pointer steps past it. In byte mode its bits 6:0 give the count when `len_8bit`=0, and bits 7:0 give it when `len_8bit`=1. In word mode bits 7:0 always give the count. A count of 0 ends the transfer after that read.
- R6: While `mem_req` is 1 and `grant` is 0, the next cycle shows the same request: the same address, direction and write data, and no state changes.
- R7: `done` is 1 for exactly one cycle, in the cycle after the final granted access, or the cycle after `start` for a zero fixed length. In that cycle `busy` and `mem_req` are 0.
- R8: At completion `irq_flag` becomes 1 if the captured mask bit is 1. It stays 1 until `irq_clear`, and a set wins over a clear in the same cycle. `irq_req` is `irq_flag` AND `irq_enable`.
- R9: `abort` returns the engine to idle in the next cycle. It produces no `done`, leaves `irq_flag` unchanged, and stops further requests.
- R10: `start` while `busy` is ignored. The running transfer continues with its captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture configuration and begin (idle only) |
| src_addr | input | 16 | Initial source pointer |
| dst_addr | input | 16 | Initial destination pointer |
| src_mode | input | 2 | Source step mode |
| dst_mode | input | 2 | Destination step mode |
| word_mode | input | 1 | 1 = 16-bit units, 0 = byte units |
| len_sel | input | 3 | Length setting; 000/111 fixed, else from data |
| xfer_len | input | 13 | Fixed unit count |
| len_8bit | input | 1 | Byte mode: use 8 bits (1) or 7 bits (0) of the length byte |
| irq_mask | input | 1 | Raise interrupt flag at completion |
| irq_enable | input | 1 | Global enable of the interrupt request |
| irq_clear | input | 1 | Clear the interrupt flag |
| abort | input | 1 | Stop the transfer immediately |
| grant | input | 1 | Memory port grant for the current request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | Access size: 1 = word, 0 = byte |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in a granted read cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq_flag | output | 1 | Sticky completion interrupt flag |
| irq_req | output | 1 | Interrupt request toward the processor |

## Verification
The bench targets several corner cases:
- Pointer wrap at 16'hFFFF and at 16'h0000 in every step mode. A design with a narrow or sign-confused adder would write to the wrong addresses.
- A length byte of 8'h85 read as 7 bits, read as 8 bits, and read in word mode where the mode bit must be ignored. A design that mixed these up would move 5 units where it should move 133, or the reverse.
- Zero counts, both fixed and taken from data. A design that decremented before testing for zero would run for thousands of units.
- Grant withheld at the first request, and a second `start` pulsed mid-transfer. A design that leaked state while stalled would show a moving address, and one that re-captured its settings would show a wrong write sequence.
- An abort must end without `done` or an interrupt.
- The interrupt flag must stay set until it is cleared.

// File: rtl/dma_xfer_pkg.sv
// Shared types for the DMA transfer engine.
// Assumes: the step-mode encoding is fixed by the configuration format.
package dma_xfer_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC1 = 2'b01,
        STEP_INC2 = 2'b10,
        STEP_DEC1 = 2'b11
    } step_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LEN  = 2'b01,
        ST_RD   = 2'b10,
        ST_WR   = 2'b11
    } xfer_state_t;
endpackage

// File: rtl/dma_ptr_step.sv
// Next value of one address pointer for its step mode.
// Assumes: wrap modulo 2^ADDR_W is wanted; purely combinational.
module dma_ptr_step
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  step_t             mode,
    output logic [ADDR_W-1:0] nxt
);
    // Select the pointer adjustment for the mode.
    always_comb begin
        unique case (mode)
            STEP_HOLD: nxt = cur;
            STEP_INC1: nxt = cur + ADDR_W'(1);
            STEP_INC2: nxt = cur + ADDR_W'(2);
            default:   nxt = cur - ADDR_W'(1);
        endcase
    end
endmodule

// File: rtl/dma_len_decode.sv
// Extracts a unit count from the first source byte.
// Assumes: CNT_W >= BYTE_W; word transfers always use the whole byte.
module dma_len_decode #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 13
) (
    input  logic [BYTE_W-1:0] len_byte,
    input  logic              word_mode,
    input  logic              len_8bit,
    output logic [CNT_W-1:0]  count
);
    // Keep the low bits, and the top bit only when the full byte is chosen.
    always_comb begin
        count = '0;
        count[BYTE_W-2:0] = len_byte[BYTE_W-2:0];
        if (word_mode || len_8bit) count[BYTE_W-1] = len_byte[BYTE_W-1];
    end
endmodule

// File: rtl/dma_irq_flag.sv
// Sticky completion flag with a gated request output.
// Assumes: a set and a clear in the same cycle leave the flag set.
module dma_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    input  logic enable,
    output logic flag,
    output logic req
);
    // Hold the flag until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set)   flag <= 1'b1;
        else if (clear) flag <= 1'b0;
    end

    // The request is forwarded only under the global enable.
    assign req = flag & enable;
endmodule

// File: rtl/dma_xfer_engine.sv
// One DMA channel's transfer sequencer: a read, then a write, per unit.
// Assumes: mem_rdata is valid in the cycle where a read is granted;
// configuration inputs are sampled only with start while idle.
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [1:0]        src_mode,
    input  logic [1:0]        dst_mode,
    input  logic              word_mode,
    input  logic [2:0]        len_sel,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic              len_8bit,
    input  logic              irq_mask,
    input  logic              irq_enable,
    input  logic              irq_clear,
    input  logic              abort,
    input  logic              grant,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              irq_flag,
    output logic              irq_req
);
    localparam int BYTE_W = 8;
    localparam int NPTR   = 2;   // index 0 source, 1 destination
    localparam int SRC    = 0;
    localparam int DST    = 1;

    xfer_state_t       state_q;
    logic [ADDR_W-1:0] ptr_q   [NPTR];
    logic [ADDR_W-1:0] ptr_nxt [NPTR];
    step_t             mode_q  [NPTR];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  len_cnt;
    logic [DATA_W-1:0] data_q;
    logic              word_q;
    logic              mask_q;
    logic              var_len;
    logic              finish;
    logic              mask_eff;

    // One step unit per pointer.
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma_ptr_step #(.ADDR_W(ADDR_W)) i_step (
            .cur  (ptr_q[g]),
            .mode (mode_q[g]),
            .nxt  (ptr_nxt[g])
        );
    end

    dma_len_decode #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) i_len (
        .len_byte  (mem_rdata[BYTE_W-1:0]),
        .word_mode (word_q),
        .len_8bit  (len_8bit),
        .count     (len_cnt)
    );

    // Classify the length setting and detect the completing cycle.
    always_comb begin
        var_len  = (len_sel != 3'b000) && (len_sel != 3'b111);
        mask_eff = (state_q == ST_IDLE) ? irq_mask : mask_q;
        finish   = 1'b0;
        if (!abort) begin
            unique case (state_q)
                ST_IDLE: finish = start && !var_len && (xfer_len == '0);
                ST_LEN:  finish = grant && (len_cnt == '0);
                ST_WR:   finish = grant && (cnt_q == CNT_W'(1));
                default: finish = 1'b0;
            endcase
        end
    end

    dma_irq_flag i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (finish && mask_eff),
        .clear  (irq_clear),
        .enable (irq_enable),
        .flag   (irq_flag),
        .req    (irq_req)
    );

    // Sequence length read, unit read and unit write; abort has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            data_q  <= '0;
            word_q  <= 1'b0;
            mask_q  <= 1'b0;
            done    <= 1'b0;
            for (int i = 0; i < NPTR; i++) begin
                ptr_q[i]  <= '0;
                mode_q[i] <= STEP_HOLD;
            end
        end else begin
            done <= finish;
            if (abort) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (start) begin
                        ptr_q[SRC]  <= src_addr;
                        ptr_q[DST]  <= dst_addr;
                        mode_q[SRC] <= step_t'(src_mode);
                        mode_q[DST] <= step_t'(dst_mode);
                        word_q      <= word_mode;
                        mask_q      <= irq_mask;
                        cnt_q       <= xfer_len;
                        if (var_len)               state_q <= ST_LEN;
                        else if (xfer_len != '0)   state_q <= ST_RD;
                    end
                    ST_LEN: if (grant) begin
                        ptr_q[SRC] <= ptr_nxt[SRC];
                        cnt_q      <= len_cnt;
                        state_q    <= (len_cnt == '0) ? ST_IDLE : ST_RD;
                    end
                    ST_RD: if (grant) begin
                        data_q     <= word_q ? mem_rdata
                                             : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
                        ptr_q[SRC] <= ptr_nxt[SRC];
                        state_q    <= ST_WR;
                    end
                    default: if (grant) begin
                        ptr_q[DST] <= ptr_nxt[DST];
                        cnt_q      <= cnt_q - CNT_W'(1);
                        state_q    <= (cnt_q == CNT_W'(1)) ? ST_IDLE : ST_RD;
                    end
                endcase
            end
        end
    end

    // Drive the memory port from the current state.
    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (state_q == ST_WR);
    assign mem_word  = word_q;
    assign mem_addr  = mem_we ? ptr_q[DST] : ptr_q[SRC];
    assign mem_wdata = data_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
// Protocol checks for dma_xfer_engine, attached by bind.
// Assumes: only top-level ports are observed.
module dma_xfer_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort,
    input logic              grant,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              busy,
    input logic              done,
    input logic              irq_flag
);
    // R1: no request outside a transfer.
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R6: an ungranted request is repeated unchanged.
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !grant && !abort) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: the completion pulse is seen only while idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req));

    // R8: the flag rises only together with completion.
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> done);

    // R9: abort ends activity without a completion pulse.
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !mem_req && !done));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .grant     (grant),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .irq_flag  (irq_flag)
);

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;
    logic        clk = 1'b0;
    logic        rst_n, start, word_mode, len_8bit, irq_mask, irq_enable, irq_clear, abort, grant;
    logic [15:0] src_addr, dst_addr, mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  src_mode, dst_mode;
    logic [2:0]  len_sel;
    logic [12:0] xfer_len;
    logic        mem_req, mem_we, mem_word, busy, done, irq_flag, irq_req;

    always #2 clk = ~clk;   // 250 MHz

    dma_xfer_engine i_dma_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_mode(src_mode), .dst_mode(dst_mode), .word_mode(word_mode), .len_sel(len_sel),
        .xfer_len(xfer_len), .len_8bit(len_8bit), .irq_mask(irq_mask), .irq_enable(irq_enable),
        .irq_clear(irq_clear), .abort(abort), .grant(grant), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    logic [15:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];

    int checks = 0;
    int errors = 0;
    logic [15:0] ea[$], ed[$], ga[$], gd[$];

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] stepf(input logic [15:0] a, input logic [1:0] m);
        case (m)
            2'b00:   return a;
            2'b01:   return a + 16'd1;
            2'b10:   return a + 16'd2;
            default: return a - 16'd1;
        endcase
    endfunction

    // Builds the expected write list from the R2..R5 rules.
    function automatic void model(input logic [15:0] s, d, input logic [1:0] sm, dm,
                                  input logic wm, input logic [2:0] ls, input logic [12:0] fl,
                                  input logic l8);
        int n;
        logic [15:0] sp, dp, v;
        sp = s; dp = d;
        ea.delete(); ed.delete();
        if (ls != 3'b000 && ls != 3'b111) begin
            v = mem[sp[7:0]];
            n = (wm || l8) ? int'(v[7:0]) : int'(v[6:0]);
            sp = stepf(sp, sm);
        end else n = int'(fl);
        for (int i = 0; i < n; i++) begin
            v = mem[sp[7:0]];
            if (!wm) v = {8'h00, v[7:0]};
            ea.push_back(dp); ed.push_back(v);
            sp = stepf(sp, sm); dp = stepf(dp, dm);
        end
    endfunction

    task automatic pulse_clear();
        @(negedge clk); irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
    endtask

    task automatic run(input logic [15:0] s, d, input logic [1:0] sm, dm, input logic wm,
                       input logic [2:0] ls, input logic [12:0] fl, input logic l8,
                       input logic msk, input int gpct, input bit retrig, input string rq);
        int cyc = 0;
        int bad = 0;
        bit accesses;
        model(s, d, sm, dm, wm, ls, fl, l8);
        accesses = (ls != 3'b000 && ls != 3'b111) || (fl != 0);
        ga.delete(); gd.delete();
        pulse_clear();
        irq_enable = 1'($urandom_range(1));
        src_addr = s; dst_addr = d; src_mode = sm; dst_mode = dm; word_mode = wm;
        len_sel = ls; xfer_len = fl; len_8bit = l8; irq_mask = msk; start = 1'b1; grant = 1'b0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done) break;
            if (cyc > 6000) begin check(0, "R7 timeout", cyc, 0); break; end
            if (retrig && cyc == 4 && busy) begin   // R10: ignored restart
                start = 1'b1; src_addr = 16'h0040; dst_addr = 16'h0090;
                len_sel = 3'b000; xfer_len = 13'd2; word_mode = ~wm;
            end
            if (cyc <= 3 && accesses) begin
                grant = 1'b0; #1;
                check(mem_req && !mem_we && mem_addr == s, "R6 stalled request", mem_addr, s);
            end else begin
                grant = ($urandom_range(99) < gpct); #1;
                if (mem_req && mem_we && grant) begin ga.push_back(mem_addr); gd.push_back(mem_wdata); end
            end
        end
        grant = 1'b0;
        check(!busy && !mem_req, "R7 idle with done", {busy, mem_req}, 0);
        check(ga.size() == ea.size(), rq, ga.size(), ea.size());
        for (int i = 0; i < ga.size() && i < ea.size(); i++)
            if (ga[i] != ea[i] || gd[i] != ed[i]) begin
                if (bad == 0) begin
                    check(0, "R2 R3 write", {ga[i], gd[i]}, {ea[i], ed[i]});
                end
                bad++;
            end
        if (bad == 0) check(1, "R2 R3 write", 0, 0);
        @(negedge clk);
        check(!done, "R7 single pulse", done, 0);
        check(irq_flag == msk, "R8 flag", irq_flag, msk);
        check(irq_req == (msk && irq_enable), "R8 request", irq_req, msk && irq_enable);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (mem[i]) mem[i] = 16'($urandom());
        rst_n = 1'b0; start = 0; abort = 0; grant = 0; irq_clear = 0; irq_enable = 0; irq_mask = 0;
        src_addr = 0; dst_addr = 0; src_mode = 0; dst_mode = 0; word_mode = 0; len_sel = 0;
        xfer_len = 0; len_8bit = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, mem_req, irq_flag, irq_req} == 5'b0, "R1 reset state",
              {busy, done, mem_req, irq_flag, irq_req}, 0);

        run(16'h0010, 16'h0100, 2'b01, 2'b01, 1'b0, 3'b000, 13'd5, 1'b0, 1'b1, 100, 0, "R4 fixed byte");
        run(16'h0020, 16'h0200, 2'b10, 2'b11, 1'b1, 3'b111, 13'd3, 1'b0, 1'b0, 60, 0, "R4 fixed word");
        run(16'h0030, 16'h0300, 2'b01, 2'b01, 1'b0, 3'b000, 13'd0, 1'b0, 1'b1, 100, 0, "R4 zero");
        run(16'hFFFF, 16'h0001, 2'b01, 2'b11, 1'b1, 3'b000, 13'd4, 1'b0, 1'b0, 80, 0, "R3 wrap");
        run(16'hFFFE, 16'h0000, 2'b10, 2'b10, 1'b0, 3'b000, 13'd3, 1'b0, 1'b1, 80, 0, "R3 wrap2");
        run(16'h0020, 16'h0030, 2'b00, 2'b00, 1'b0, 3'b000, 13'd3, 1'b0, 0, 100, 0, "R3 hold");
        mem[8'h50] = 16'h1285;
        run(16'h0050, 16'h0400, 2'b01, 2'b01, 1'b0, 3'b001, 13'd9, 1'b0, 1'b1, 100, 0, "R5 seven bit");
        run(16'h0050, 16'h0400, 2'b01, 2'b01, 1'b0, 3'b010, 13'd9, 1'b1, 1'b0, 100, 0, "R5 eight bit");
        run(16'h0050, 16'h0400, 2'b01, 2'b10, 1'b1, 3'b011, 13'd9, 1'b0, 1'b1, 100, 0, "R5 word");
        mem[8'h60] = 16'h0080;
        run(16'h0060, 16'h0500, 2'b01, 2'b01, 1'b0, 3'b100, 13'd9, 1'b0, 1'b1, 100, 0, "R5 zero count");
        run(16'h0070, 16'h0600, 2'b01, 2'b01, 1'b0, 3'b000, 13'd6, 1'b0, 1'b0, 70, 1, "R10 restart ignored");

        for (int k = 0; k < 40; k++) begin
            logic [2:0] ls;
            ls = 3'($urandom_range(7));
            run(16'($urandom()), 16'($urandom()), 2'($urandom_range(3)), 2'($urandom_range(3)),
                1'($urandom_range(1)), ls, 13'($urandom_range(24)), 1'($urandom_range(1)),
                1'($urandom_range(1)), 30 + int'($urandom_range(70)), 0,
                (ls == 3'b000 || ls == 3'b111) ? "R4 random" : "R5 random");
        end

        // R9: abort mid-transfer
        pulse_clear();
        src_addr = 16'h0010; dst_addr = 16'h0700; src_mode = 2'b01; dst_mode = 2'b01;
        len_sel = 3'b000; xfer_len = 13'd30; word_mode = 1'b0; irq_mask = 1'b1;
        start = 1'b1; grant = 1'b1;
        begin
            bit seen_done = 0;
            for (int c = 0; c < 7; c++) begin @(negedge clk); start = 1'b0; if (done) seen_done = 1; end
            abort = 1'b1;
            @(negedge clk); abort = 1'b0;
            check(busy == 1'b0 && mem_req == 1'b0, "R9 idle after abort", {busy, mem_req}, 0);
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                if (done || mem_req) seen_done = 1;
            end
            check(!seen_done, "R9 no done or request", seen_done, 0);
            check(!irq_flag, "R9 no interrupt", irq_flag, 0);
        end
        grant = 1'b0;

        // R8: flag sticky until cleared
        run(16'h0010, 16'h0800, 2'b01, 2'b01, 1'b0, 3'b000, 13'd1, 1'b0, 1'b1, 100, 0, "R8 setup");
        repeat (5) @(negedge clk);
        check(irq_flag, "R8 sticky", irq_flag, 1);
        pulse_clear();
        check(!irq_flag && !irq_req, "R8 cleared", irq_flag, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule